// File: doc/BRIEF.md
# Serial Port Bus Register Front End

This block sits between a single-cycle processor I/O bus and the engine of a serial port. The bus carries an address, a read strobe, a write strobe, write data and combinational read data. Only two bus addresses are decoded, and each one reaches two physical registers. The data address is split by direction. A write fills the transmit buffer and a read returns the receive buffer. The control address is split by timing. A single read returns the upper byte of the baud divisor. A read that comes straight after a read of the same address in the previous clock cycle returns the frame control register.

Writes to the control address are steered by bit 7 of the write data. Transmit writes are accepted only while the transmit buffer is empty. An accepted write with the transmitter enabled produces a one-cycle load pulse toward the engine. The engine hands received characters in through a push strobe and releases the transmit buffer with a load acknowledge. The block applies the character size held in the frame control register to data in both directions.

Top module: `sport_bus_regs`

## Requirements
- R1: After reset the transmit buffer and the receive buffer hold 0x00, the transmit-empty flag is 1, the divisor byte is 0x00, the frame control register is 0x03 (8-bit characters) and the load pulse is low.
- R2: A write to the data address while the transmit-empty flag is 1 stores the masked write data in the transmit buffer, and it clears the flag from the next cycle on.
- R3: A write to the data address while the transmit-empty flag is 0 leaves the transmit buffer unchanged.
- R4: An accepted data write drives `tx_load` high for exactly the next cycle if `tx_en` was high in the write cycle. An accepted write with `tx_en` low gives no pulse.
- R5: `tx_ack` sets the transmit-empty flag again when the buffer is full. When the buffer is already empty, `tx_ack` changes nothing.
- R6: The character size is frame control bits [2:0]. The codes are 000=5, 001=6, 010=7 and 011=8 bits, and codes 1xx are treated as 8 bits. Transmit data bits above the character size are stored as zero.
- R7: A pulse on `rx_push` stores `rx_byte`, with bits above the character size forced to zero, in the receive buffer. A read of the data address returns that buffer in the same cycle.
- R8: A read of the control address, when the control address was not read in the previous cycle, returns {0, divisor[6:0]}.
- R9: A read of the control address that directly follows a control-address read in the previous cycle returns {1, frame control[6:0]}. Three back-to-back reads give divisor, control, control. Any cycle without a control-address read breaks the sequence.
- R10: A write to the control address with data bit 7 = 1 loads bits [6:0] into the frame control register. With bit 7 = 0 it loads bits [6:0] into the divisor byte.
- R11: `bus_rdata` is 0x00 in any cycle that has no read of a decoded address. This covers cycles without a read strobe and reads of other addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | I/O address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| tx_en | input | 1 | Transmitter enabled |
| tx_ack | input | 1 | Engine has taken the transmit byte |
| rx_push | input | 1 | Received character valid |
| rx_byte | input | 8 | Received character |
| tx_data | output | 8 | Transmit buffer contents |
| tx_load | output | 1 | Load pulse to the transmitter |
| tx_empty | output | 1 | Transmit buffer empty flag |
| baud_hi | output | 7 | Upper baud-divisor bits |
| frame_ctl | output | 7 | Frame control register |

## Verification
The bench builds the block with its default parameters: a 6-bit address, data at 0x0C and control at 0x20. With only two decoded addresses, every length-four sequence of the four bus operations (idle, control read, data read, read of an undecoded address) can be driven. This exposes each case of the timed alias, including broken and restarted sequences. The 3-bit size field is small enough that all eight codes are swept in both the transmit and receive directions, each with several byte patterns. The expected masks are computed arithmetically.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int BYTE_W = 8;

    // read-sequence FSM: was the control address read last cycle
    typedef enum logic {
        RS_IDLE  = 1'b0,
        RS_ARMED = 1'b1
    } rdseq_e;

    // transmit buffer occupancy
    typedef enum logic {
        TB_EMPTY = 1'b0,
        TB_FULL  = 1'b1
    } txbuf_e;

    // which source drives the read data this cycle
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_DATA = 2'd1,
        RD_DIV  = 2'd2,
        RD_CTL  = 2'd3
    } rdsel_e;

    function automatic logic [BYTE_W-1:0] char_mask(input logic [2:0] size_code);
        logic [BYTE_W-1:0] m;
        unique case (size_code)
            3'd0:    m = 8'h1F;
            3'd1:    m = 8'h3F;
            3'd2:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sport_rdseq.sv
module sport_rdseq
    import sport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_rd,
    output logic armed
);

    rdseq_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // IDLE -> ARMED on a control read; ARMED stays on another, else back to IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (ctl_rd)  state_d = RS_ARMED;
            RS_ARMED: if (!ctl_rd) state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == RS_ARMED);
    end

endmodule

// File: rtl/sport_txbuf.sv
module sport_txbuf
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              tx_en,
    input  logic              ack,
    input  logic [BYTE_W-1:0] wdata_m,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_empty,
    output logic              tx_load
);

    txbuf_e            state_q, state_d;
    logic [BYTE_W-1:0] buf_q;
    logic              load_q;
    logic              accept;

    assign accept = wr_req && (state_q == TB_EMPTY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TB_EMPTY;
            buf_q   <= '0;
            load_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            load_q  <= accept && tx_en;
            if (accept) buf_q <= wdata_m;
        end
    end

    // EMPTY -> FULL on an accepted write; FULL -> EMPTY on acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_EMPTY: if (accept) state_d = TB_FULL;
            TB_FULL:  if (ack)    state_d = TB_EMPTY;
        endcase
    end

    always_comb begin
        tx_data  = buf_q;
        tx_empty = (state_q == TB_EMPTY);
        tx_load  = load_q;
    end

endmodule

// File: rtl/sport_rxbuf.sv
module sport_rxbuf
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] din_m,
    output logic [BYTE_W-1:0] rx_data
);

    logic [BYTE_W-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    buf_q <= '0;
        else if (push) buf_q <= din_m;
    end

    assign rx_data = buf_q;

endmodule

// File: rtl/sport_bus_regs.sv
module sport_bus_regs
    import sport_pkg::*;
#(
    parameter int            AW        = 6,
    parameter logic [AW-1:0] DATA_ADDR = 6'h0C,
    parameter logic [AW-1:0] CTRL_ADDR = 6'h20,
    parameter logic [6:0]    CTL_RST   = 7'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          tx_en,
    input  logic          tx_ack,
    input  logic          rx_push,
    input  logic [7:0]    rx_byte,
    output logic [7:0]    tx_data,
    output logic          tx_load,
    output logic          tx_empty,
    output logic [6:0]    baud_hi,
    output logic [6:0]    frame_ctl
);

    localparam int LOW_W = BYTE_W - 1;

    logic             hit_data, hit_ctrl;
    logic             ctl_rd, armed;
    logic [LOW_W-1:0] div_q, ctl_q;
    logic [BYTE_W-1:0] mask, rx_data;
    rdsel_e           rsel;

    assign hit_data = (bus_addr == DATA_ADDR);
    assign hit_ctrl = (bus_addr == CTRL_ADDR);
    assign ctl_rd   = bus_rd && hit_ctrl;
    assign mask     = char_mask(ctl_q[2:0]);

    // control-address writes, steered by the top data bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            ctl_q <= CTL_RST;
        end else if (bus_wr && hit_ctrl) begin
            if (bus_wdata[BYTE_W-1]) ctl_q <= bus_wdata[LOW_W-1:0];
            else                     div_q <= bus_wdata[LOW_W-1:0];
        end
    end

    sport_rdseq u_rdseq (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_rd(ctl_rd),
        .armed (armed)
    );

    sport_txbuf u_txbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (bus_wr && hit_data),
        .tx_en   (tx_en),
        .ack     (tx_ack),
        .wdata_m (bus_wdata & mask),
        .tx_data (tx_data),
        .tx_empty(tx_empty),
        .tx_load (tx_load)
    );

    sport_rxbuf u_rxbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (rx_push),
        .din_m  (rx_byte & mask),
        .rx_data(rx_data)
    );

    // read source selection
    always_comb begin
        rsel = RD_NONE;
        if (bus_rd && hit_data)      rsel = RD_DATA;
        else if (ctl_rd && armed)    rsel = RD_CTL;
        else if (ctl_rd)             rsel = RD_DIV;
    end

    always_comb begin
        unique case (rsel)
            RD_DATA: bus_rdata = rx_data;
            RD_DIV:  bus_rdata = {1'b0, div_q};
            RD_CTL:  bus_rdata = {1'b1, ctl_q};
            default: bus_rdata = '0;
        endcase
    end

    assign baud_hi   = div_q;
    assign frame_ctl = ctl_q;

endmodule

// File: rtl/sport_bus_regs_chk.sv
module sport_bus_regs_chk #(
    parameter int            AW        = 6,
    parameter logic [AW-1:0] DATA_ADDR = 6'h0C,
    parameter logic [AW-1:0] CTRL_ADDR = 6'h20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [7:0]    bus_rdata,
    input logic          tx_en,
    input logic          tx_ack,
    input logic [7:0]    tx_data,
    input logic          tx_load,
    input logic          tx_empty,
    input logic [6:0]    baud_hi,
    input logic [6:0]    frame_ctl
);

    logic rd_ctl, wr_data, prev_rd_ctl, prev_acc_en;

    assign rd_ctl  = bus_rd && (bus_addr == CTRL_ADDR);
    assign wr_data = bus_wr && (bus_addr == DATA_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rd_ctl <= 1'b0;
            prev_acc_en <= 1'b0;
        end else begin
            prev_rd_ctl <= rd_ctl;
            prev_acc_en <= wr_data && tx_empty && tx_en;
        end
    end

    a_r8_div_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl && !prev_rd_ctl) |-> (bus_rdata == {1'b0, baud_hi}));

    a_r9_ctl_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl && prev_rd_ctl) |-> (bus_rdata == {1'b1, frame_ctl}));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));

    a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_empty) |=> !tx_empty);

    a_r3_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !tx_empty) |=> $stable(tx_data));

    a_r4_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> prev_acc_en);

    a_r5_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && tx_ack) |=> tx_empty);

endmodule

bind sport_bus_regs sport_bus_regs_chk #(
    .AW(AW), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .tx_en(tx_en), .tx_ack(tx_ack),
    .tx_data(tx_data), .tx_load(tx_load), .tx_empty(tx_empty),
    .baud_hi(baud_hi), .frame_ctl(frame_ctl)
);

// File: tb/sim_sport_bus_regs.sv
module sim_sport_bus_regs;

    localparam int         AW = 6;
    localparam logic [5:0] DA = 6'h0C;
    localparam logic [5:0] CA = 6'h20;
    localparam logic [5:0] OA = 6'h01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       tx_en = 1'b0, tx_ack = 1'b0, rx_push = 1'b0;
    logic [7:0] rx_byte = '0, tx_data;
    logic       tx_load, tx_empty;
    logic [6:0] baud_hi, frame_ctl;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    sport_bus_regs #(.AW(AW), .DATA_ADDR(DA), .CTRL_ADDR(CA)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_en(tx_en), .tx_ack(tx_ack), .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_data(tx_data), .tx_load(tx_load), .tx_empty(tx_empty),
        .baud_hi(baud_hi), .frame_ctl(frame_ctl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        bus_rd = 1'b0; bus_wr = 1'b0; tx_ack = 1'b0; rx_push = 1'b0;
    endtask

    task automatic write(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        idle();
    endtask

    function automatic logic [7:0] mexp(input int sz);
        int bits;
        bits = (sz > 3) ? 8 : 5 + sz;
        return 8'((1 << bits) - 1);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] pats [4];
        logic [7:0] b, m, prev_tx, exp;
        logic       prev;
        int         op;
        pats[0] = 8'hFF; pats[1] = 8'hA5; pats[2] = 8'h5A; pats[3] = 8'h3C;

        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 tx_data", tx_data, 0);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 baud_hi", baud_hi, 0);
        check("R1 frame_ctl", frame_ctl, 7'h03);
        check("R1 tx_load", tx_load, 0);
        bus_addr = DA; bus_rd = 1'b1; #1;
        check("R1 rx buffer", bus_rdata, 0);
        idle(); tick();

        // transmit sweep over all size codes
        for (int sz = 0; sz < 8; sz++) begin
            write(CA, {1'b1, 4'b0, 3'(sz)});
            check("R10 ctl write", frame_ctl, {4'b0, 3'(sz)});
            m = mexp(sz);
            for (int k = 0; k < 4; k++) begin
                b = pats[k];
                tx_en = k[0];
                write(DA, b);
                check("R2/R6 tx masked", tx_data, b & m);
                check("R2 empty cleared", tx_empty, 0);
                check("R4 load pulse", tx_load, k[0]);
                prev_tx = tx_data;
                write(DA, ~b);
                check("R3 dropped write", tx_data, prev_tx);
                check("R3 still full", tx_empty, 0);
                check("R4 pulse one cycle", tx_load, 0);
                tx_ack = 1'b1; tick(); idle();
                check("R5 ack frees", tx_empty, 1);
                tx_ack = 1'b1; tick(); idle();
                check("R5 ack when empty", tx_empty, 1);
                check("R5 data kept", tx_data, prev_tx);
            end
        end
        tx_en = 1'b0;

        // receive sweep
        for (int sz = 0; sz < 8; sz++) begin
            write(CA, {1'b1, 4'b0, 3'(sz)});
            m = mexp(sz);
            for (int k = 0; k < 4; k++) begin
                rx_push = 1'b1; rx_byte = pats[k] ^ 8'(sz);
                tick(); idle();
                bus_addr = DA; bus_rd = 1'b1; #1;
                check("R7 rx masked", bus_rdata, (pats[k] ^ 8'(sz)) & m);
                bus_rd = 1'b0; #1;
                check("R11 no read", bus_rdata, 0);
            end
        end

        // steering of control-address writes
        write(CA, 8'h55);
        check("R10 divisor", baud_hi, 7'h55);
        check("R10 ctl untouched", frame_ctl, 7'h07);
        write(CA, 8'hAB);
        check("R10 ctl", frame_ctl, 7'h2B);
        check("R10 divisor untouched", baud_hi, 7'h55);
        rx_push = 1'b1; rx_byte = 8'hC3; tick(); idle();

        // every 4-cycle sequence of: none, ctrl read, data read, other read
        for (int p = 0; p < 256; p++) begin
            idle(); tick();
            prev = 1'b0;
            for (int i = 0; i < 4; i++) begin
                op = (p >> (2 * i)) & 3;
                bus_rd = (op != 0);
                bus_addr = (op == 1) ? CA : (op == 2) ? DA : OA;
                #1;
                case (op)
                    1:       exp = prev ? 8'hAB : 8'h55;
                    2:       exp = 8'hC3;
                    default: exp = 8'h00;
                endcase
                if (op == 1 && prev)  check("R9 ctl follow", bus_rdata, exp);
                else if (op == 1)     check("R8 divisor first", bus_rdata, exp);
                else if (op == 2)     check("R7 data read", bus_rdata, exp);
                else                  check("R11 zero", bus_rdata, exp);
                tick();
                prev = (op == 1);
            end
        end
        idle(); tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule